// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Bit Engine

This block is the bit-level master engine for a two-wire serial bus with open-drain lines (SCL clock, SDA data). It owns no line drivers. It produces two pull-enables: a high output pulls the line low, and a low output lets the external pull-up raise the line. It reads the resolved SDA level back through a two-flop synchronizer. A host hands it one command at a time: bus recovery, START, STOP, byte write, or byte read with a chosen acknowledge level. The engine plays the command out as a fixed sequence of equal time slots on the lines, then pulses `done`.

Each slot lasts `div_limit + 1` clock cycles. The slot counter restarts when a command is accepted, so each command takes a whole number of slots. At the start of each slot the engine may change a line. At the end of some slots it samples SDA. Line levels persist from one command to the next, so the host builds complete transfers from START, one or more bytes, and STOP. The slave acknowledge bit and the received byte stay on the outputs between commands.

Recovery frees a slave that holds SDA low after an interrupted transfer. It clocks SCL nine times with SDA released, then finishes with a STOP.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done`, `scl_pull` and `sda_pull` are all 0 (both lines released).
- R2: A command is taken only when `busy` is low and `cmd_valid` is high at a clock edge. `busy` rises after that edge. A `cmd_valid` raised while `busy` is high has no effect on the running command or afterwards.
- R3: Each slot lasts `div_limit + 1` clocks. Command lengths in slots are 4 for START, 4 for STOP, 37 for write, 29 for read and 40 for recovery. `done` appears exactly that many clocks after the accepting edge.
- R4: START (`cmd_op` = 0) first releases SDA, then releases SCL, then pulls SDA low while SCL is high. It ends with SCL released and SDA pulled.
- R5: STOP (`cmd_op` = 1) pulls SCL and SDA low, then releases SCL, then releases SDA while SCL is high. It ends with both lines released.
- R6: Write (`cmd_op` = 2) sends `cmd_wdata` MSB first on eight SCL high phases. SDA never changes while SCL is high.
- R7: After the eighth write bit, the engine releases SDA for a ninth SCL high phase. It latches the SDA level at the end of that phase into `ack_nack` (0 = slave acknowledged, 1 = not acknowledged). It ends with SCL pulled low.
- R8: Read (`cmd_op` = 3) releases SDA and shifts eight bits, MSB first, into `rd_data`. Each bit is sampled at the end of the first slot of its SCL high phase.
- R9: After a read, the engine drives `cmd_rd_nack` on SDA during a ninth SCL high phase (0 pulls SDA low, 1 releases it). It ends with SCL pulled low.
- R10: Recovery (`cmd_op` = 4) gives nine SCL low/high pulses with SDA released, each half two slots long, then a STOP. That is ten SCL rising edges and exactly one STOP condition, ending with both lines released.
- R11: `done` is high for exactly one clock, in the first cycle with `busy` low after a command.
- R12: `rd_data` changes only during a read and `ack_nack` only during a write. Both hold while idle and across the other commands.
- R13: `cmd_op` values 5, 6 and 7 are not accepted: `busy`, `done` and both lines stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_limit | input | DIV_W | Slot length minus one, in clocks |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0 START, 1 STOP, 2 write, 3 read, 4 recovery) |
| cmd_wdata | input | 8 | Byte to send on a write |
| cmd_rd_nack | input | 1 | Acknowledge level to drive after a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_nack | output | 1 | SDA level seen in the acknowledge slot of the last write |
| rd_data | output | 8 | Byte received by the last read |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The assertions assume `div_limit` stays constant while `busy` is high. They also assume that, outside START and STOP, the other bus party changes SDA only while SCL is low. The bench holds the limit fixed across each command. Its slave model updates its SDA pull only at sample points where SCL is observed low.

The two-flop synchronizer needs sampling points at least two clocks after an SDA change. For that reason, reads and acknowledge checks use `div_limit` values of 1 to 3. The sweeps cover all 256 data bytes for writes and for reads, with alternating acknowledge levels.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam int OP_W   = 3;
  localparam int DATA_W = 8;
  localparam int GRP_W  = 4;
  localparam int SLOT_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_START   = 3'd0,
    OP_STOP    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_RECOVER = 3'd4
  } eng_op_e;

  // one line action applied at the start of a slot
  typedef struct packed {
    logic en;
    logic lvl;
  } line_act_t;

  localparam line_act_t ACT_NONE = '{en: 1'b0, lvl: 1'b0};
  localparam line_act_t ACT_LOW  = '{en: 1'b1, lvl: 1'b0};
  localparam line_act_t ACT_HIGH = '{en: 1'b1, lvl: 1'b1};

  function automatic logic op_is_legal(input logic [OP_W-1:0] op);
    return op <= OP_RECOVER;
  endfunction

endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_end;
  logic             cnt_en;

  assign at_end = (cnt_q == limit);
  assign tick   = run & at_end & ~restart;
  assign cnt_en = run | restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic pipe_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q[i] <= RST_VAL;
        end else begin
          pipe_q[i] <= d;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q[i] <= RST_VAL;
        end else begin
          pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/i2c_step_len.sv
// Slot-table shape of each command: how many slots a group has, how many
// groups the command has, and where the SDA line is sampled.
module i2c_step_len
  import i2c_eng_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [GRP_W-1:0]  grp,
  input  logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] slot_last,
  output logic [GRP_W-1:0]  grp_last,
  output logic              smp_ack,
  output logic              smp_bit
);

  logic in_bits;

  assign in_bits = (grp < GRP_W'(DATA_W));

  always_comb begin
    slot_last = '0;
    grp_last  = '0;
    smp_ack   = 1'b0;
    smp_bit   = 1'b0;
    case (op)
      OP_START, OP_STOP: begin
        slot_last = SLOT_W'(3);
      end
      OP_WRITE: begin
        grp_last  = GRP_W'(DATA_W);
        slot_last = in_bits ? SLOT_W'(3) : SLOT_W'(4);
        smp_ack   = !in_bits && (slot == SLOT_W'(3));
      end
      OP_READ: begin
        grp_last  = GRP_W'(DATA_W);
        slot_last = in_bits ? SLOT_W'(2) : SLOT_W'(4);
        smp_bit   = in_bits && (slot == SLOT_W'(1));
      end
      OP_RECOVER: begin
        grp_last  = GRP_W'(DATA_W + 1);
        slot_last = SLOT_W'(3);
      end
      default: begin
        slot_last = '0;
      end
    endcase
  end

endmodule

// File: rtl/i2c_step_act.sv
// Line actions taken at the start of a given slot of a given command.
module i2c_step_act
  import i2c_eng_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [GRP_W-1:0]  grp,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] dat,
  input  logic              ack_lvl,
  output line_act_t         scl_act,
  output line_act_t         sda_act
);

  logic      in_bits;
  logic      in_pulses;
  logic      data_bit;
  line_act_t stop_scl;
  line_act_t stop_sda;

  assign in_bits   = (grp < GRP_W'(DATA_W));
  assign in_pulses = (grp < GRP_W'(DATA_W + 1));
  assign data_bit  = dat[~grp[2:0]];

  // stop condition: SCL low, SDA low, SCL high, SDA high
  always_comb begin
    stop_scl = ACT_NONE;
    stop_sda = ACT_NONE;
    case (slot)
      SLOT_W'(0): stop_scl = ACT_LOW;
      SLOT_W'(1): stop_sda = ACT_LOW;
      SLOT_W'(2): stop_scl = ACT_HIGH;
      SLOT_W'(3): stop_sda = ACT_HIGH;
      default: stop_scl = ACT_NONE;
    endcase
  end

  always_comb begin
    scl_act = ACT_NONE;
    sda_act = ACT_NONE;
    case (op)
      OP_START: begin
        case (slot)
          SLOT_W'(1): sda_act = ACT_HIGH;
          SLOT_W'(2): scl_act = ACT_HIGH;
          SLOT_W'(3): sda_act = ACT_LOW;
          default: sda_act = ACT_NONE;
        endcase
      end
      OP_STOP: begin
        scl_act = stop_scl;
        sda_act = stop_sda;
      end
      OP_WRITE: begin
        case (slot)
          SLOT_W'(0): scl_act = ACT_LOW;
          SLOT_W'(1): sda_act = in_bits ? line_act_t'{en: 1'b1, lvl: data_bit} : ACT_HIGH;
          SLOT_W'(2): scl_act = ACT_HIGH;
          SLOT_W'(4): scl_act = ACT_LOW;
          default: scl_act = ACT_NONE;
        endcase
      end
      OP_READ: begin
        if (in_bits) begin
          case (slot)
            SLOT_W'(0): begin
              scl_act = ACT_LOW;
              sda_act = ACT_HIGH;
            end
            SLOT_W'(1): scl_act = ACT_HIGH;
            default: scl_act = ACT_NONE;
          endcase
        end else begin
          case (slot)
            SLOT_W'(0): scl_act = ACT_LOW;
            SLOT_W'(1): sda_act = line_act_t'{en: 1'b1, lvl: ack_lvl};
            SLOT_W'(2): scl_act = ACT_HIGH;
            SLOT_W'(4): scl_act = ACT_LOW;
            default: scl_act = ACT_NONE;
          endcase
        end
      end
      OP_RECOVER: begin
        if (in_pulses) begin
          case (slot)
            SLOT_W'(0): begin
              scl_act = ACT_LOW;
              sda_act = ACT_HIGH;
            end
            SLOT_W'(2): scl_act = ACT_HIGH;
            default: scl_act = ACT_NONE;
          endcase
        end else begin
          scl_act = stop_scl;
          sda_act = stop_sda;
        end
      end
      default: begin
        scl_act = ACT_NONE;
      end
    endcase
  end

endmodule

// File: rtl/i2c_seq.sv
module i2c_seq
  import i2c_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_rd_nack,
  input  logic              tick,
  input  logic              sda_s,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic [OP_W-1:0]   cur_op,
  output logic              scl_lvl,
  output logic              sda_lvl,
  output logic              ack_nack,
  output logic [DATA_W-1:0] rd_data
);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              ackl_q, ackl_d;
  logic              scl_q, scl_d;
  logic              sda_q, sda_d;
  logic              ackn_q, ackn_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  logic [SLOT_W-1:0] cur_slot_last;
  logic [GRP_W-1:0]  cur_grp_last;
  logic              cur_smp_ack;
  logic              cur_smp_bit;
  logic              end_slot;
  logic              end_cmd;
  logic              step;
  logic              adv;

  logic [OP_W-1:0]   tgt_op;
  logic [GRP_W-1:0]  tgt_grp;
  logic [SLOT_W-1:0] tgt_slot;
  logic [DATA_W-1:0] tgt_dat;
  logic              tgt_ackl;
  line_act_t         tgt_scl;
  line_act_t         tgt_sda;

  i2c_step_len u_len (
    .op        (op_q),
    .grp       (grp_q),
    .slot      (slot_q),
    .slot_last (cur_slot_last),
    .grp_last  (cur_grp_last),
    .smp_ack   (cur_smp_ack),
    .smp_bit   (cur_smp_bit)
  );

  assign accept   = !busy_q && cmd_valid && op_is_legal(cmd_op);
  assign step     = busy_q && tick;
  assign end_slot = (slot_q == cur_slot_last);
  assign end_cmd  = end_slot && (grp_q == cur_grp_last);
  assign adv      = accept || (step && !end_cmd);

  // position whose line actions are applied this cycle
  always_comb begin
    if (accept) begin
      tgt_op   = cmd_op;
      tgt_dat  = cmd_wdata;
      tgt_ackl = cmd_rd_nack;
      tgt_grp  = '0;
      tgt_slot = '0;
    end else begin
      tgt_op   = op_q;
      tgt_dat  = dat_q;
      tgt_ackl = ackl_q;
      tgt_grp  = end_slot ? grp_q + 1'b1 : grp_q;
      tgt_slot = end_slot ? '0 : slot_q + 1'b1;
    end
  end

  i2c_step_act u_act (
    .op      (tgt_op),
    .grp     (tgt_grp),
    .slot    (tgt_slot),
    .dat     (tgt_dat),
    .ack_lvl (tgt_ackl),
    .scl_act (tgt_scl),
    .sda_act (tgt_sda)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    op_d   = op_q;
    grp_d  = grp_q;
    slot_d = slot_q;
    dat_d  = dat_q;
    ackl_d = ackl_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    ackn_d = ackn_q;
    rd_d   = rd_q;
    if (accept) begin
      busy_d = 1'b1;
      op_d   = cmd_op;
      dat_d  = cmd_wdata;
      ackl_d = cmd_rd_nack;
      grp_d  = '0;
      slot_d = '0;
    end else if (step) begin
      if (cur_smp_ack) begin
        ackn_d = sda_s;
      end
      if (cur_smp_bit) begin
        rd_d = {rd_q[DATA_W-2:0], sda_s};
      end
      if (end_cmd) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        grp_d  = tgt_grp;
        slot_d = tgt_slot;
      end
    end
    if (adv) begin
      if (tgt_scl.en) begin
        scl_d = tgt_scl.lvl;
      end
      if (tgt_sda.en) begin
        sda_d = tgt_sda.lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
      grp_q  <= '0;
      slot_q <= '0;
      dat_q  <= '0;
      ackl_q <= 1'b1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      ackn_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      op_q   <= op_d;
      grp_q  <= grp_d;
      slot_q <= slot_d;
      dat_q  <= dat_d;
      ackl_q <= ackl_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      ackn_q <= ackn_d;
      rd_q   <= rd_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cur_op   = op_q;
  assign scl_lvl  = scl_q;
  assign sda_lvl  = sda_q;
  assign ack_nack = ackn_q;
  assign rd_data  = rd_q;

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_eng_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_limit,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_rd_nack,
  output logic              busy,
  output logic              done,
  output logic              ack_nack,
  output logic [DATA_W-1:0] rd_data,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              sda_in
);

  logic            tick;
  logic            accept;
  logic            sda_s;
  logic            scl_lvl;
  logic            sda_lvl;
  logic [OP_W-1:0] cur_op;

  i2c_tick_gen #(
    .DIV_W (DIV_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (accept),
    .limit   (div_limit),
    .tick    (tick)
  );

  i2c_sync2 #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_in),
    .q     (sda_s)
  );

  i2c_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_wdata   (cmd_wdata),
    .cmd_rd_nack (cmd_rd_nack),
    .tick        (tick),
    .sda_s       (sda_s),
    .accept      (accept),
    .busy        (busy),
    .done        (done),
    .cur_op      (cur_op),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .ack_nack    (ack_nack),
    .rd_data     (rd_data)
  );

  assign scl_pull = ~scl_lvl;
  assign sda_pull = ~sda_lvl;

endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       ack_nack,
  input logic [7:0] rd_data,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic [2:0] cur_op
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R11

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op <= 3'd4) |=> busy); // R2

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_op)); // R2

  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op > 3'd4) |=> !busy); // R13

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(rd_data) && $stable(ack_nack))); // R12

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (cur_op == 3'd2 || cur_op == 3'd3)
     && !scl_pull && !$past(scl_pull)) |-> $stable(sda_pull)); // R6

  AST_START_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_op == 3'd0) |-> (!scl_pull && sda_pull)); // R4

  AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cur_op == 3'd1 || cur_op == 3'd4)) |-> (!scl_pull && !sda_pull)); // R5

endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .ack_nack  (ack_nack),
  .rd_data   (rd_data),
  .scl_pull  (scl_pull),
  .sda_pull  (sda_pull),
  .cur_op    (cur_op)
);

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
module i2c_bit_engine_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div_limit;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic       cmd_rd_nack;
  logic       busy, done, ack_nack, scl_pull, sda_pull, sda_in;
  logic [7:0] rd_data;

  logic       slave_pull = 1'b0;
  int         slv_mode = 0;      // 0 idle, 1 ack a write, 2 send a byte
  logic       slv_ack = 1'b0;    // 1: slave pulls SDA in the ack phase
  logic [7:0] slv_byte = 8'h00;
  int         rise_base = 0;

  int n_rise = 0, n_fall = 0, n_start = 0, n_stop = 0, n_done = 0;
  logic [8:0] cap = '0;
  logic       nine_pull = 1'b0;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  assign sda_in = ~(sda_pull | slave_pull);

  i2c_bit_engine uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_limit   (div_limit),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_wdata   (cmd_wdata),
    .cmd_rd_nack (cmd_rd_nack),
    .busy        (busy),
    .done        (done),
    .ack_nack    (ack_nack),
    .rd_data     (rd_data),
    .scl_pull    (scl_pull),
    .sda_pull    (sda_pull),
    .sda_in      (sda_in)
  );

  // bus monitor and slave model, all at the falling clock edge
  always @(negedge clk) begin
    logic scl, sda;
    int   k;
    scl = ~scl_pull;
    sda = sda_in;
    if (done) n_done++;
    if (scl && !prev_scl) begin
      n_rise++;
      cap = {cap[7:0], sda};
      if (n_rise - rise_base == 9) nine_pull = sda_pull;
    end
    if (!scl && prev_scl) n_fall++;
    if (scl && prev_scl && sda != prev_sda) begin
      if (!sda) n_start++;
      else n_stop++;
    end
    k = n_rise - rise_base;
    if (!scl) begin
      if (slv_mode == 1) slave_pull = (k == 8) ? slv_ack : 1'b0;
      else if (slv_mode == 2) slave_pull = (k < 8) ? ~slv_byte[7-k] : 1'b0;
      else slave_pull = 1'b0;
    end
    prev_scl = scl;
    prev_sda = ~(sda_pull | slave_pull);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int b_rise, b_fall, b_start, b_stop, b_done;

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input logic nk,
                         input int slots, input bit poke, input string tag);
    int cycles;
    @(negedge clk);
    rise_base = n_rise;
    b_rise = n_rise; b_fall = n_fall; b_start = n_start; b_stop = n_stop; b_done = n_done;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_rd_nack = nk;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " R2 busy after accept"}, int'(busy), 1);
    cycles = 0;
    while (!done && cycles < 20000) begin
      @(posedge clk);
      @(negedge clk);
      cycles++;
      if (poke && !done) begin
        cmd_valid = 1'b1; cmd_op = 3'd4;
      end else begin
        cmd_valid = 1'b0;
      end
    end
    cmd_valid = 1'b0;
    chk({tag, " R3 length"}, cycles, slots * (int'(div_limit) + 1));
    chk({tag, " R11 idle at done"}, int'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R11 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] keep_rd;
    logic       keep_ack;
    logic       keep_scl;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_wdata = '0; cmd_rd_nack = 1'b1;
    div_limit = 8'd2;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 lines in reset", int'({scl_pull, sda_pull}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 lines after reset", int'({scl_pull, sda_pull}), 0);

    // R10 recovery
    slv_mode = 0;
    run_cmd(3'd4, 8'h00, 1'b1, 40, 1'b0, "recover");
    chk("R10 scl rises", n_rise - b_rise, 10);
    chk("R10 scl falls", n_fall - b_fall, 10);
    chk("R10 one stop", n_stop - b_stop, 1);
    chk("R10 no start", n_start - b_start, 0);
    chk("R10 lines released", int'({scl_pull, sda_pull}), 0);

    // R4 start, with requests poked during busy (R2)
    run_cmd(3'd0, 8'h00, 1'b1, 4, 1'b1, "start");
    chk("R4 one start", n_start - b_start, 1);
    chk("R4 no stop", n_stop - b_stop, 0);
    chk("R4 end levels", int'({scl_pull, sda_pull}), 1);
    repeat (20) @(negedge clk);
    chk("R2 stays idle after poke", int'(busy), 0);
    chk("R2 single done", n_done - b_done, 1);

    // R6 R7 write sweep
    div_limit = 8'd1;
    slv_mode = 1;
    for (int b = 0; b < 256; b++) begin
      slv_ack = b[0];
      run_cmd(3'd2, 8'(b), 1'b1, 37, 1'b0, "write");
      chk("R6 write byte", int'(cap[8:1]), b);
      chk("R6 no sda change with scl high", (n_start - b_start) + (n_stop - b_stop), 0);
      chk("R7 ack bit", int'(ack_nack), int'(!slv_ack));
      chk("R7 master released sda", int'(nine_pull), 0);
      chk("R7 scl left low", int'(scl_pull), 1);
    end

    // R8 R9 read sweep
    slv_mode = 2;
    for (int b = 0; b < 256; b++) begin
      slv_byte = 8'(b);
      run_cmd(3'd3, 8'h00, b[1], 29, 1'b0, "read");
      chk("R8 read byte", int'(rd_data), b);
      chk("R8 no sda change with scl high", (n_start - b_start) + (n_stop - b_stop), 0);
      chk("R9 master ack drive", int'(nine_pull), int'(!b[1]));
      chk("R9 scl left low", int'(scl_pull), 1);
    end
    chk("R12 ack held over reads", int'(ack_nack), 0);

    // R5 stop and R12 hold at a slower rate
    div_limit = 8'd3;
    slv_mode = 0;
    keep_rd = rd_data;
    run_cmd(3'd0, 8'h00, 1'b1, 4, 1'b0, "start slow");
    run_cmd(3'd1, 8'h00, 1'b1, 4, 1'b0, "stop");
    chk("R5 one stop", n_stop - b_stop, 1);
    chk("R5 lines released", int'({scl_pull, sda_pull}), 0);
    chk("R12 rd held over start stop", int'(rd_data), int'(keep_rd));

    slv_mode = 1; slv_ack = 1'b0;
    run_cmd(3'd2, 8'hA5, 1'b1, 37, 1'b0, "write slow");
    chk("R6 write slow byte", int'(cap[8:1]), 8'hA5);
    chk("R7 nack seen", int'(ack_nack), 1);
    chk("R12 rd held over write", int'(rd_data), int'(keep_rd));

    slv_mode = 2; slv_byte = 8'h3C;
    keep_ack = ack_nack;
    run_cmd(3'd3, 8'h00, 1'b1, 29, 1'b0, "read slow");
    chk("R8 read slow byte", int'(rd_data), 8'h3C);
    chk("R9 nack drive releases", int'(nine_pull), 0);
    chk("R12 ack held over read", int'(ack_nack), int'(keep_ack));
    repeat (30) @(negedge clk);
    chk("R12 rd held idle", int'(rd_data), 8'h3C);

    // R13 illegal codes
    slv_mode = 0;
    for (int c = 5; c < 8; c++) begin
      b_done = n_done;
      keep_scl = scl_pull;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(c);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      chk("R13 bad op not busy", int'(busy), 0);
      chk("R13 bad op no done", n_done - b_done, 0);
      chk("R13 bad op lines", int'(scl_pull), int'(keep_scl));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule